// File: doc/BRIEF.md
# Way-Memoizing Set-Associative Instruction Cache

This block is a 4-way set-associative instruction cache for a single-issue, in-order fetch stage. It remembers where earlier fetches found their lines, so that a later fetch to a known line reads one data way and skips the tag compare. These remembered way pointers are kept in two places. A 16-entry direct-mapped branch target table holds a way field for each branch target. Each cache line holds a pointer to the way of the line that follows it in address order.

The fetch stage gives every request a source code. The code says whether the request is a sequential step, a branch target (with the branch address), or neither. When no valid pointer applies, the cache does a full four-way compare. It then stores the way it found in the pointer that should have supplied it. A miss raises a one-line refill request, and the cache stalls until the line arrives. When a line is replaced, every pointer that could lead to it is cleared in that same cycle.

Top module: `wm_icache`

## Requirements
- R1: After reset every line, every next-line pointer and every branch-table way pointer is invalid. req_ready is high, resp_valid and refill_req are low, and the first fetch of any address misses.
- R2: A fetch that finds its line by full compare answers one cycle after it is accepted. The answer has resp_hit=1, resp_memo=0, resp_data equal to the stored word at that address, and resp_way equal to the way holding the line.
- R3: A miss answers with resp_hit=0. From the next cycle on, refill_req is high, refill_line carries req_addr[AW-1:OFFW], and req_ready is low. One cycle after refill_valid, refill_req is low and req_ready is high again, and the line then hits.
- R4: Refills pick their victim way with one round-robin counter that starts at way 0 after reset and advances by one on each refill.
- R5: req_src=2 marks a branch-target fetch. The branch table is indexed by the low bits of req_br_pc. When the entry's tag matches and its target equals req_addr, a first fetch does a full compare and records the way. Later such fetches answer with resp_memo=1 and the same word and way.
- R6: req_src=1 marks a sequential fetch. When its line is the line after the last line that hit, a first crossing does a full compare and records the way in that last line. Later crossings answer with resp_memo=1 and the correct word.
- R7: A pointer is used only through a matching branch-table entry or a valid next-line pointer. A branch-target fetch with a branch tag mismatch or a target mismatch uses a full compare, and so does a fetch with req_src=0.
- R8: Refilling (set s, way w) clears the way pointer of every branch-table entry whose target maps to set s and way w. A later branch-target fetch to the evicted address therefore misses.
- R9: Refilling (set s, way w) clears every next-line pointer in set s-1 (modulo the set count) that names way w. A later sequential crossing to the evicted line therefore misses.
- R10: An update on the branch resolve port that gives the same branch and target as a valid entry keeps that entry's way pointer. Any other update allocates the entry with its way pointer cleared.
- R11: Pointer-path and full-compare hits both answer exactly one cycle after acceptance, and a pointer-path answer is always a hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Fetch request |
| req_ready | output | 1 | Cache can accept a fetch (low while refilling) |
| req_addr | input | AW | Word address to fetch |
| req_src | input | 2 | 0 other, 1 sequential, 2 branch target |
| req_br_pc | input | AW | Branch address for a branch-target fetch |
| resp_valid | output | 1 | Answer for the fetch accepted the cycle before |
| resp_hit | output | 1 | Word found |
| resp_memo | output | 1 | Answer came through a stored way pointer |
| resp_way | output | 2 | Way that supplied the word |
| resp_data | output | DW | Instruction word |
| upd_valid | input | 1 | Branch resolved as taken |
| upd_pc | input | AW | Address of the resolved branch |
| upd_target | input | AW | Its target address |
| refill_req | output | 1 | Line requested from the next level |
| refill_line | output | AW-OFFW | Line address requested |
| refill_valid | input | 1 | Refill line present |
| refill_data | input | LWORDS*DW | Refill line, word 0 in the low bits |

## Verification
A stale or misdirected way pointer cannot be seen directly at the ports. It shows up on the first fetch that uses it: the answer arrives in the normal cycle with resp_memo set, but resp_data holds the wrong line's word or resp_hit is wrong. A pointer that is never recorded, or that is cleared too eagerly, shows only as resp_memo staying low on the second visit. For that reason every scenario visits each line twice and compares data, way and path flag against a memory model. Missing invalidation is exposed right after the eviction, because the evicted address must miss rather than return another line's word.

// File: rtl/wm_pkg.sv
package wm_pkg;
    localparam int NWAY = 4;
    localparam int WAYW = 2;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_SEQ  = 2'd1,
        SRC_BR   = 2'd2
    } fetch_src_e;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_FILL = 1'b1
    } fill_state_e;

    typedef struct packed {
        logic            ok;
        logic [WAYW-1:0] way;
    } way_ptr_t;

    function automatic logic [WAYW-1:0] way_of(input logic [NWAY-1:0] v);
        logic [WAYW-1:0] r;
        r = '0;
        for (int i = 0; i < NWAY; i++)
            if (v[i]) r = WAYW'(i);
        return r;
    endfunction
endpackage

// File: rtl/wm_victim.sv
module wm_victim
    import wm_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            adv,
    output logic [WAYW-1:0] way
);
    always_ff @(posedge clk) begin
        if (rst)      way <= '0;
        else if (adv) way <= way + 1'b1;
    end
endmodule

// File: rtl/wm_btb.sv
module wm_btb
    import wm_pkg::*;
#(
    parameter int AW      = 16,
    parameter int ENTRIES = 16,
    parameter int OFFW    = 2,
    parameter int SETW    = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [AW-1:0]   look_pc,
    input  logic [AW-1:0]   look_target,
    output logic            look_match,
    output way_ptr_t        look_ptr,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_pc,
    input  logic [WAYW-1:0] wr_way,
    input  logic            upd_valid,
    input  logic [AW-1:0]   upd_pc,
    input  logic [AW-1:0]   upd_target,
    input  logic            inv_en,
    input  logic [SETW-1:0] inv_set,
    input  logic [WAYW-1:0] inv_way
);
    localparam int IDXW = $clog2(ENTRIES);
    localparam int BTW  = AW - IDXW;

    logic            e_valid [ENTRIES];
    logic            e_wok   [ENTRIES];
    logic [BTW-1:0]  e_tag   [ENTRIES];
    logic [AW-1:0]   e_tgt   [ENTRIES];
    logic [WAYW-1:0] e_way   [ENTRIES];

    logic [IDXW-1:0] li, wi, ui;
    logic            upd_new;

    assign li = look_pc[IDXW-1:0];
    assign wi = wr_pc[IDXW-1:0];
    assign ui = upd_pc[IDXW-1:0];

    assign look_match   = e_valid[li] && e_tag[li] == look_pc[AW-1:IDXW] && e_tgt[li] == look_target;
    assign look_ptr.ok  = e_wok[li];
    assign look_ptr.way = e_way[li];

    assign upd_new = upd_valid &&
                     !(e_valid[ui] && e_tag[ui] == upd_pc[AW-1:IDXW] && e_tgt[ui] == upd_target);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int e = 0; e < ENTRIES; e++) begin
                e_valid[e] <= 1'b0;
                e_wok[e]   <= 1'b0;
            end
        end else begin
            for (int e = 0; e < ENTRIES; e++)
                if (inv_en && e_wok[e] && e_tgt[e][OFFW +: SETW] == inv_set && e_way[e] == inv_way)
                    e_wok[e] <= 1'b0;
            if (wr_en) e_wok[wi] <= 1'b1;
            if (upd_new) begin
                e_valid[ui] <= 1'b1;
                e_wok[ui]   <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) e_way[wi] <= wr_way;
        if (upd_new) begin
            e_tag[ui] <= upd_pc[AW-1:IDXW];
            e_tgt[ui] <= upd_target;
        end
    end
endmodule

// File: rtl/wm_lines.sv
module wm_lines
    import wm_pkg::*;
#(
    parameter int SETS   = 8,
    parameter int LWORDS = 4,
    parameter int DW     = 32,
    parameter int TAGW   = 11
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [$clog2(SETS)-1:0]   rd_set,
    input  logic [TAGW-1:0]           rd_tag,
    input  logic [$clog2(LWORDS)-1:0] rd_off,
    input  logic [WAYW-1:0]           sel_way,
    output logic [NWAY-1:0]           hit_vec,
    output logic [DW-1:0]             sel_word,
    input  logic [$clog2(SETS)-1:0]   q_set,
    input  logic [WAYW-1:0]           q_way,
    output way_ptr_t                  q_ptr,
    input  logic                      fill_en,
    input  logic [$clog2(SETS)-1:0]   fill_set,
    input  logic [WAYW-1:0]           fill_way,
    input  logic [TAGW-1:0]           fill_tag,
    input  logic [LWORDS*DW-1:0]      fill_data,
    input  logic                      ptr_en,
    input  logic [$clog2(SETS)-1:0]   ptr_set,
    input  logic [WAYW-1:0]           ptr_way,
    input  logic [WAYW-1:0]           ptr_val
);
    localparam int SETW = $clog2(SETS);

    logic            ln_valid [SETS][NWAY];
    logic [TAGW-1:0] ln_tag   [SETS][NWAY];
    logic [DW-1:0]   ln_data  [SETS][NWAY][LWORDS];
    logic            nx_ok    [SETS][NWAY];
    logic [WAYW-1:0] nx_way   [SETS][NWAY];

    logic [SETW-1:0] prev_set;
    assign prev_set = fill_set - 1'b1;

    for (genvar g = 0; g < NWAY; g++) begin : g_cmp
        assign hit_vec[g] = ln_valid[rd_set][g] && ln_tag[rd_set][g] == rd_tag;
    end

    assign sel_word  = ln_data[rd_set][sel_way][rd_off];
    assign q_ptr.ok  = nx_ok[q_set][q_way];
    assign q_ptr.way = nx_way[q_set][q_way];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < NWAY; w++) begin
                    ln_valid[s][w] <= 1'b0;
                    nx_ok[s][w]    <= 1'b0;
                end
        end else begin
            if (ptr_en) nx_ok[ptr_set][ptr_way] <= 1'b1;
            if (fill_en) begin
                for (int w = 0; w < NWAY; w++)
                    if (nx_way[prev_set][w] == fill_way) nx_ok[prev_set][w] <= 1'b0;
                ln_valid[fill_set][fill_way] <= 1'b1;
                nx_ok[fill_set][fill_way]    <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (ptr_en) nx_way[ptr_set][ptr_way] <= ptr_val;
        if (fill_en) begin
            ln_tag[fill_set][fill_way] <= fill_tag;
            for (int k = 0; k < LWORDS; k++)
                ln_data[fill_set][fill_way][k] <= fill_data[k*DW +: DW];
        end
    end
endmodule

// File: rtl/wm_icache.sv
module wm_icache
    import wm_pkg::*;
#(
    parameter int AW     = 16,
    parameter int DW     = 32,
    parameter int SETS   = 8,
    parameter int LWORDS = 4,
    parameter int BTB_N  = 16
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               req_valid,
    output logic                               req_ready,
    input  logic [AW-1:0]                      req_addr,
    input  logic [1:0]                         req_src,
    input  logic [AW-1:0]                      req_br_pc,
    output logic                               resp_valid,
    output logic                               resp_hit,
    output logic                               resp_memo,
    output logic [1:0]                         resp_way,
    output logic [DW-1:0]                      resp_data,
    input  logic                               upd_valid,
    input  logic [AW-1:0]                      upd_pc,
    input  logic [AW-1:0]                      upd_target,
    output logic                               refill_req,
    output logic [AW-$clog2(LWORDS)-1:0]       refill_line,
    input  logic                               refill_valid,
    input  logic [LWORDS*DW-1:0]               refill_data
);
    localparam int OFFW = $clog2(LWORDS);
    localparam int SETW = $clog2(SETS);
    localparam int TAGW = AW - OFFW - SETW;
    localparam int LAW  = AW - OFFW;

    fill_state_e     state;
    fetch_src_e      src;
    logic            last_ok;
    logic [LAW-1:0]  last_line, miss_line;
    logic [WAYW-1:0] last_way, victim, use_way;
    logic [LAW-1:0]  req_line;
    logic [SETW-1:0] last_set;
    logic [NWAY-1:0] hit_vec;
    logic [DW-1:0]   sel_word;
    way_ptr_t        seq_ptr, br_ptr, memo;
    logic            br_match, seq_cross, br_ok, full_hit, accept, got, fill_en;

    assign src       = fetch_src_e'(req_src);
    assign req_line  = req_addr[AW-1:OFFW];
    assign last_set  = last_line[SETW-1:0];
    assign seq_cross = src == SRC_SEQ && last_ok && req_line == LAW'(last_line + 1'b1);
    assign br_ok     = src == SRC_BR && br_match;

    always_comb begin
        memo = '0;
        if (seq_cross && seq_ptr.ok)  memo = seq_ptr;
        else if (br_ok && br_ptr.ok)  memo = br_ptr;
    end

    assign full_hit  = |hit_vec;
    assign use_way   = memo.ok ? memo.way : way_of(hit_vec);
    assign req_ready = state == ST_RUN;
    assign accept    = req_valid && req_ready;
    assign got       = memo.ok || full_hit;
    assign fill_en   = state == ST_FILL && refill_valid;

    assign refill_req  = state == ST_FILL;
    assign refill_line = miss_line;

    wm_lines #(.SETS(SETS), .LWORDS(LWORDS), .DW(DW), .TAGW(TAGW)) u_lines (
        .clk(clk), .rst(rst),
        .rd_set(req_addr[OFFW +: SETW]), .rd_tag(req_addr[AW-1 -: TAGW]),
        .rd_off(req_addr[OFFW-1:0]), .sel_way(use_way),
        .hit_vec(hit_vec), .sel_word(sel_word),
        .q_set(last_set), .q_way(last_way), .q_ptr(seq_ptr),
        .fill_en(fill_en), .fill_set(miss_line[SETW-1:0]), .fill_way(victim),
        .fill_tag(miss_line[LAW-1:SETW]), .fill_data(refill_data),
        .ptr_en(accept && !memo.ok && full_hit && seq_cross),
        .ptr_set(last_set), .ptr_way(last_way), .ptr_val(use_way)
    );

    wm_btb #(.AW(AW), .ENTRIES(BTB_N), .OFFW(OFFW), .SETW(SETW)) u_btb (
        .clk(clk), .rst(rst),
        .look_pc(req_br_pc), .look_target(req_addr),
        .look_match(br_match), .look_ptr(br_ptr),
        .wr_en(accept && full_hit && br_ok && !br_ptr.ok),
        .wr_pc(req_br_pc), .wr_way(use_way),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_target(upd_target),
        .inv_en(fill_en), .inv_set(miss_line[SETW-1:0]), .inv_way(victim)
    );

    wm_victim u_victim (.clk(clk), .rst(rst), .adv(fill_en), .way(victim));

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_RUN;
            last_ok    <= 1'b0;
            last_line  <= '0;
            last_way   <= '0;
            miss_line  <= '0;
            resp_valid <= 1'b0;
            resp_hit   <= 1'b0;
            resp_memo  <= 1'b0;
            resp_way   <= '0;
            resp_data  <= '0;
        end else begin
            resp_valid <= accept;
            resp_hit   <= accept && got;
            resp_memo  <= accept && memo.ok;
            resp_way   <= use_way;
            resp_data  <= sel_word;
            if (accept && got) begin
                last_ok   <= 1'b1;
                last_line <= req_line;
                last_way  <= use_way;
            end
            if (accept && !got) begin
                state     <= ST_FILL;
                miss_line <= req_line;
            end
            if (fill_en) begin
                state <= ST_RUN;
                if (last_ok && last_set == miss_line[SETW-1:0] && last_way == victim)
                    last_ok <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/wm_icache_chk.sv
module wm_icache_chk (
    input logic       clk,
    input logic       rst,
    input logic       req_valid,
    input logic       req_ready,
    input logic       resp_valid,
    input logic       resp_hit,
    input logic       resp_memo,
    input logic       refill_req,
    input logic       refill_valid,
    input logic [3:0] hit_vec
);
    a_r11_answer_follows: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> resp_valid);
    a_r11_no_spurious_answer: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> $past(req_valid && req_ready));
    a_r11_memo_is_hit: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && resp_memo) |-> resp_hit);
    a_r3_miss_stalls: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && !resp_hit) |-> (refill_req && !req_ready));
    a_r3_fill_releases: assert property (@(posedge clk) disable iff (rst)
        (refill_req && refill_valid) |=> (!refill_req && req_ready));
    a_r2_single_way_match: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_vec));
endmodule

bind wm_icache wm_icache_chk u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_memo(resp_memo),
    .refill_req(refill_req), .refill_valid(refill_valid), .hit_vec(hit_vec)
);

// File: tb/wm_icache_bench.sv
`timescale 1ns/1ps
module wm_icache_bench;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic [15:0]  req_addr = '0;
    logic [1:0]   req_src = '0;
    logic [15:0]  req_br_pc = '0;
    logic         resp_valid, resp_hit, resp_memo;
    logic [1:0]   resp_way;
    logic [31:0]  resp_data;
    logic         upd_valid = 1'b0;
    logic [15:0]  upd_pc = '0, upd_target = '0;
    logic         refill_req;
    logic [13:0]  refill_line;
    logic         refill_valid = 1'b0;
    logic [127:0] refill_data = '0;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    wm_icache u_wm_icache (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_src(req_src), .req_br_pc(req_br_pc),
        .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_memo(resp_memo),
        .resp_way(resp_way), .resp_data(resp_data),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_target(upd_target),
        .refill_req(refill_req), .refill_line(refill_line),
        .refill_valid(refill_valid), .refill_data(refill_data)
    );

    function automatic logic [31:0] mem_word(input logic [15:0] a);
        return {a, a ^ 16'hA5C3};
    endfunction

    task automatic check(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic do_update(input logic [15:0] pc, input logic [15:0] tgt);
        @(negedge clk);
        upd_valid = 1'b1; upd_pc = pc; upd_target = tgt;
        @(negedge clk);
        upd_valid = 1'b0;
    endtask

    // One fetch; on expected miss also serves the refill and checks the handshake (R3).
    task automatic fetch(input logic [15:0] a, input logic [1:0] src, input logic [15:0] pc,
                         input bit ehit, input bit ememo, input logic [1:0] eway, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_src = src; req_br_pc = pc;
        @(negedge clk);
        req_valid = 1'b0;
        check(tag, "resp_valid", 64'(resp_valid), 64'd1);
        check(tag, "resp_hit", 64'(resp_hit), 64'(ehit));
        if (ehit) begin
            check(tag, "resp_data", 64'(resp_data), 64'(mem_word(a)));
            check(tag, "resp_memo", 64'(resp_memo), 64'(ememo));
            check(tag, "resp_way", 64'(resp_way), 64'(eway));
        end else begin
            check({tag, "/R3"}, "refill_req", 64'(refill_req), 64'd1);
            check({tag, "/R3"}, "refill_line", 64'(refill_line), 64'(a[15:2]));
            check({tag, "/R3"}, "req_ready", 64'(req_ready), 64'd0);
            refill_valid = 1'b1;
            for (int k = 0; k < 4; k++)
                refill_data[k*32 +: 32] = mem_word({a[15:2], 2'(k)});
            @(negedge clk);
            refill_valid = 1'b0;
            check({tag, "/R3"}, "refill_req after fill", 64'(refill_req), 64'd0);
            check({tag, "/R3"}, "req_ready after fill", 64'(req_ready), 64'd1);
        end
    endtask

    task automatic t_reset;
        check("R1", "req_ready", 64'(req_ready), 64'd1);
        check("R1", "resp_valid", 64'(resp_valid), 64'd0);
        check("R1", "refill_req", 64'(refill_req), 64'd0);
        fetch(16'h0040, 2'd0, 16'h0, 1'b0, 1'b0, 2'd0, "R1 first fetch misses");
    endtask

    task automatic t_basic;
        fetch(16'h0040, 2'd0, 16'h0, 1'b1, 1'b0, 2'd0, "R2 R4 hit in way0");
        fetch(16'h0042, 2'd0, 16'h0, 1'b1, 1'b0, 2'd0, "R2 other word");
        fetch(16'h0003, 2'd0, 16'h0, 1'b0, 1'b0, 2'd0, "R3 miss set0");
        fetch(16'h0003, 2'd0, 16'h0, 1'b1, 1'b0, 2'd1, "R4 second victim way1");
    endtask

    task automatic t_seq;
        fetch(16'h0043, 2'd0, 16'h0, 1'b1, 1'b0, 2'd0, "R2 last word of line");
        fetch(16'h0044, 2'd1, 16'h0, 1'b0, 1'b0, 2'd0, "R6 crossing misses");
        fetch(16'h0044, 2'd1, 16'h0, 1'b1, 1'b0, 2'd2, "R6 R4 first crossing full way2");
        fetch(16'h0043, 2'd0, 16'h0, 1'b1, 1'b0, 2'd0, "R6 back to line");
        fetch(16'h0045, 2'd1, 16'h0, 1'b1, 1'b1, 2'd2, "R6 R11 crossing via pointer");
        fetch(16'h0046, 2'd0, 16'h0, 1'b1, 1'b0, 2'd2, "R7 src0 full compare");
    endtask

    task automatic t_branch;
        do_update(16'h0100, 16'h0044);
        fetch(16'h0044, 2'd2, 16'h0100, 1'b1, 1'b0, 2'd2, "R5 first target fetch full");
        fetch(16'h0044, 2'd2, 16'h0100, 1'b1, 1'b1, 2'd2, "R5 R11 target via pointer");
        fetch(16'h0044, 2'd2, 16'h0110, 1'b1, 1'b0, 2'd2, "R7 branch tag mismatch");
        do_update(16'h0100, 16'h0044);
        fetch(16'h0044, 2'd2, 16'h0100, 1'b1, 1'b1, 2'd2, "R10 same update keeps pointer");
        do_update(16'h0100, 16'h0040);
        fetch(16'h0044, 2'd2, 16'h0100, 1'b1, 1'b0, 2'd2, "R7 target mismatch");
        fetch(16'h0040, 2'd2, 16'h0100, 1'b1, 1'b0, 2'd0, "R10 new target starts clear");
        fetch(16'h0040, 2'd2, 16'h0100, 1'b1, 1'b1, 2'd0, "R5 new target via pointer");
    endtask

    task automatic t_replace;
        fetch(16'h00FC, 2'd0, 16'h0, 1'b0, 1'b0, 2'd0, "R4 miss set7");
        fetch(16'h00FC, 2'd0, 16'h0, 1'b1, 1'b0, 2'd3, "R4 victim way3");
        fetch(16'h0080, 2'd0, 16'h0, 1'b0, 1'b0, 2'd0, "R8 evict set0 way0");
        fetch(16'h0080, 2'd0, 16'h0, 1'b1, 1'b0, 2'd0, "R4 wrap to way0");
        fetch(16'h0040, 2'd2, 16'h0100, 1'b0, 1'b0, 2'd0, "R8 stale target misses");
        fetch(16'h0040, 2'd2, 16'h0100, 1'b1, 1'b0, 2'd1, "R8 relearn full way1");
        fetch(16'h0040, 2'd2, 16'h0100, 1'b1, 1'b1, 2'd1, "R8 relearned pointer");
        fetch(16'h0043, 2'd0, 16'h0, 1'b1, 1'b0, 2'd1, "R9 setup line");
        fetch(16'h0044, 2'd1, 16'h0, 1'b1, 1'b0, 2'd2, "R9 fresh line pointer clear");
        fetch(16'h0043, 2'd0, 16'h0, 1'b1, 1'b0, 2'd1, "R9 setup line again");
        fetch(16'h0044, 2'd1, 16'h0, 1'b1, 1'b1, 2'd2, "R9 crossing via pointer");
        fetch(16'h0024, 2'd0, 16'h0, 1'b0, 1'b0, 2'd0, "R9 evict set1 way2");
        fetch(16'h0024, 2'd0, 16'h0, 1'b1, 1'b0, 2'd2, "R9 new line way2");
        fetch(16'h0043, 2'd0, 16'h0, 1'b1, 1'b0, 2'd1, "R9 back to line");
        fetch(16'h0044, 2'd1, 16'h0, 1'b0, 1'b0, 2'd0, "R9 stale next pointer misses");
        fetch(16'h0044, 2'd1, 16'h0, 1'b1, 1'b0, 2'd3, "R9 relearn way3");
        fetch(16'h0043, 2'd0, 16'h0, 1'b1, 1'b0, 2'd1, "R9 line again");
        fetch(16'h0047, 2'd1, 16'h0, 1'b1, 1'b1, 2'd3, "R9 relearned pointer");
    endtask

    task automatic report;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_basic;
        t_seq;
        t_branch;
        t_replace;
        done = 1'b1;
        report;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            report;
        end
    end
endmodule